// File: doc/BRIEF.md
# DMA Channel Command and Status Unit

This unit is the register front end of one channel of a descriptor-driven DMA engine. Software reaches it over a plain 32-bit register bus with a word address. The unit turns writes into one-cycle action pulses for the channel datapath: start, continue, stop after drain, abort, FIFO reset and full reset. It keeps the channel's interrupt enables and its transfer configuration, and collects event and error reports from the datapath into a status word that drives a single interrupt line.

Interrupt enables have no plain read-modify-write path. Each enable has its own write-one-to-set bit and write-one-to-clear bit, so separate software contexts can change one enable without disturbing the others. Sticky events are never cleared by writing the status word. They are cleared by dedicated command bits, by a start (for done), or by a full reset.

Word addresses: 0 is the command register (write-only, reads zero), 1 is control, 2 is status (read-only), and 3 reads zero. Reads are combinational from the address. Writes take effect at the clock edge that samples `reg_en_i & reg_we_i`.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, control and status read 0x0000_0000. Command address 0 and the unused address 3 always read zero. All action pulses and `irq_o` are low.
- R2: A command write drives each selected action pulse high for exactly the one cycle after the write. Bit 0 maps to `start_o`, bit 1 to `cont_o`, bit 2 to `stop_o`, bit 3 to `abort_o`, bit 4 to `fifo_rst_o` and bit 31 to `dma_rst_o`. Several bits in one write give several pulses together.
- R3: Control bit pairs (set/clear) control the enables: 31/30 global, 29/28 link pause, 27/26 segment, 25/24 done, 23/22 memory ready, 21/20 device ready, 19/18 link complete, 17/16 ring. Each enable reads back at its set-bit position, and clear positions read 0. A write with both bits of a pair at 0 leaves that enable unchanged.
- R4: When one write carries both the set bit and the clear bit of a pair, the enable is cleared.
- R5: Control bits are written directly: bit 15 FIFO disable (`fifo_dis_o`), bit 14 burst enable (`burst_en_o`), bit 3 device-to-memory direction (`dev_to_mem_o`), bits 2:0 mode (`mode_o`). Mode encodings are 0 normal, 1 continue, 2 ring, 4 short chaining, 5 long chaining. These bits read back at the same positions.
- R6: A control write whose mode field is 3, 6 or 7 leaves the mode unchanged and still updates the other fields.
- R7: An `evt_i` bit that is high for one cycle sets its sticky status bit, and the bit stays set until it is cleared. The mapping from `evt_i` bit to status bit is 0→29 (link pause), 1→27 (segment), 2→25 (done), 3→23 (memory ready), 4→21 (device ready), 5→19 (link complete), 6→17 (ring).
- R8: Command bit 7 clears done, bit 5 clears link complete and bit 6 clears ring. Start (bit 0) also clears done. If an event arrives in the same cycle as its clear, the status bit stays set.
- R9: Each of the 2-bit error fields captures the first nonzero code seen on its input and holds it: link at 5:4, memory at 3:2, device at 1:0. Code 1 is bus error, 2 is retry error, 3 is other. `xfer_err_i` sets bit 9. Bit 15 is the OR of bit 9 and all three error fields.
- R10: The abort command sets status bit 14. `hw_abort_i` sets bit 13, `stopped_i` sets bit 12 and `end_i` sets bit 8. All of these bits are sticky.
- R11: Status bit 31 and `irq_o` are combinational. They equal the global enable ANDed with the OR of every sticky event ANDed with its own enable.
- R12: Command bit 31 clears the mode and config fields and the whole status word. The change is visible in the cycle after the write, and it wins over events or an abort arriving in the same cycle. The interrupt enables are kept.
- R13: Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| evt_i | input | 7 | Datapath event pulses (mapping in R7) |
| hw_abort_i | input | 1 | Hardware abort report |
| stopped_i | input | 1 | Channel stopped report |
| end_i | input | 1 | Transfer end report |
| xfer_err_i | input | 1 | Transfer error report |
| link_err_i | input | 2 | Link port error code |
| mem_err_i | input | 2 | Memory port error code |
| dev_err_i | input | 2 | Device port error code |
| start_o | output | 1 | Start pulse |
| cont_o | output | 1 | Continue pulse |
| stop_o | output | 1 | Stop-after-drain pulse |
| abort_o | output | 1 | Abort pulse |
| fifo_rst_o | output | 1 | FIFO reset pulse |
| dma_rst_o | output | 1 | Full channel reset pulse |
| fifo_dis_o | output | 1 | FIFO disable |
| burst_en_o | output | 1 | Burst enable |
| dev_to_mem_o | output | 1 | Direction, 1 = device to memory |
| mode_o | output | 3 | Transfer mode |
| irq_o | output | 1 | Channel interrupt |

## Verification
The enable pairs are tried with set-only, clear-only, both-zero and both-one patterns on the global and done pairs. This separates a correct set/clear decode from plain register writes and from a set-priority decode. Sticky events are raised alone, next to each other and in the same cycle as their own clear command. This separates correct clear routing, a mix-up between the done, link and ring clears, and a clear that wins over a new event. The interrupt is tried with the global enable off, then on, then with the per-event enable removed, which isolates each term of the gating. Error fields receive a second, different code, which shows whether the first code is held or overwritten. A full reset is issued with the config, status and enables all nonzero, which shows exactly what the reset clears and what it keeps.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned N_EV   = 7;
  localparam int unsigned N_IE   = N_EV + 1;   // index 0 is the global enable
  localparam int unsigned N_PORT = 3;          // dev, mem, link error fields

  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  // command bit positions
  localparam int unsigned C_START   = 0;
  localparam int unsigned C_CONT    = 1;
  localparam int unsigned C_STOP    = 2;
  localparam int unsigned C_ABORT   = 3;
  localparam int unsigned C_FRST    = 4;
  localparam int unsigned C_CLR_LNK = 5;
  localparam int unsigned C_CLR_RNG = 6;
  localparam int unsigned C_CLR_DN  = 7;
  localparam int unsigned C_DRST    = 31;

  // control field positions
  localparam int unsigned K_FIFO_DIS = 15;
  localparam int unsigned K_BURST    = 14;
  localparam int unsigned K_DIR      = 3;

  // event indices (status bit = 29 - 2*idx)
  localparam int unsigned E_DONE = 2;
  localparam int unsigned E_LINK = 5;
  localparam int unsigned E_RING = 6;

  // status flag positions
  localparam int unsigned S_IRQ   = 31;
  localparam int unsigned S_ERR   = 15;
  localparam int unsigned S_SWAB  = 14;
  localparam int unsigned S_HWAB  = 13;
  localparam int unsigned S_STOP  = 12;
  localparam int unsigned S_XFER  = 9;
  localparam int unsigned S_END   = 8;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_CONT   = 3'd1,
    MODE_RING   = 3'd2,
    MODE_LINK_S = 3'd4,
    MODE_LINK_L = 3'd5
  } mode_e;

  typedef struct packed {
    logic  fifo_dis;
    logic  burst_en;
    logic  dev_to_mem;
    mode_e mode;
  } chan_cfg_t;

  typedef struct packed {
    logic dma_rst;
    logic fifo_rst;
    logic abort;
    logic stop;
    logic cont;
    logic start;
  } act_t;

  function automatic logic mode_ok(input logic [2:0] m);
    return (m == MODE_NORMAL) || (m == MODE_CONT) || (m == MODE_RING) ||
           (m == MODE_LINK_S) || (m == MODE_LINK_L);
  endfunction
endpackage

// File: rtl/dma_chan_cmd.sv
`timescale 1ns/1ps
module dma_chan_cmd
  import dma_chan_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output act_t          act_o,
  output logic          clr_done_o,
  output logic          clr_link_o,
  output logic          clr_ring_o,
  output logic          sw_abort_o,
  output logic          rst_now_o
);
  act_t act_d, act_q;
  logic unused_bits;

  assign unused_bits = ^wdata_i[DW-2:C_CLR_DN+1];

  always_comb begin
    act_d          = '0;
    act_d.start    = we_i & wdata_i[C_START];
    act_d.cont     = we_i & wdata_i[C_CONT];
    act_d.stop     = we_i & wdata_i[C_STOP];
    act_d.abort    = we_i & wdata_i[C_ABORT];
    act_d.fifo_rst = we_i & wdata_i[C_FRST];
    act_d.dma_rst  = we_i & wdata_i[C_DRST];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign act_o      = act_q;
  // clears land on the write edge, start also retires done
  assign clr_done_o = we_i & (wdata_i[C_CLR_DN] | wdata_i[C_START]);
  assign clr_link_o = we_i & wdata_i[C_CLR_LNK];
  assign clr_ring_o = we_i & wdata_i[C_CLR_RNG];
  assign sw_abort_o = act_d.abort;
  assign rst_now_o  = act_d.dma_rst;
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NIE = N_IE
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           rst_now_i,
  output logic [NIE-1:0] ie_o,
  output chan_cfg_t      cfg_o,
  output logic [DW-1:0]  rdata_o
);
  localparam int unsigned PAIR_LO = DW - 2*NIE;

  chan_cfg_t cfg_q;
  logic      unused_bits;

  assign unused_bits = ^{wdata_i[K_BURST-1:K_DIR+1], wdata_i[PAIR_LO-1:K_FIFO_DIS+1]};

  for (genvar k = 0; k < NIE; k++) begin : g_ie
    localparam int unsigned SET_B = DW - 1 - 2*k;
    localparam int unsigned CLR_B = DW - 2 - 2*k;
    logic ie_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     ie_q <= 1'b0;
      else if (we_i && wdata_i[CLR_B]) ie_q <= 1'b0;  // clear beats set
      else if (we_i && wdata_i[SET_B]) ie_q <= 1'b1;
    end
    assign ie_o[k] = ie_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (rst_now_i) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.fifo_dis   <= wdata_i[K_FIFO_DIS];
      cfg_q.burst_en   <= wdata_i[K_BURST];
      cfg_q.dev_to_mem <= wdata_i[K_DIR];
      if (mode_ok(wdata_i[2:0])) cfg_q.mode <= mode_e'(wdata_i[2:0]);
    end
  end

  always_comb begin
    rdata_o             = '0;
    for (int k = 0; k < int'(NIE); k++) rdata_o[DW-1-2*k] = ie_o[k];
    rdata_o[K_FIFO_DIS] = cfg_q.fifo_dis;
    rdata_o[K_BURST]    = cfg_q.burst_en;
    rdata_o[K_DIR]      = cfg_q.dev_to_mem;
    rdata_o[2:0]        = cfg_q.mode;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/dma_chan_status.sv
`timescale 1ns/1ps
module dma_chan_status
  import dma_chan_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NEV = N_EV,
  parameter int unsigned NP  = N_PORT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NEV-1:0]    evt_i,
  input  logic              hw_abort_i,
  input  logic              stopped_i,
  input  logic              end_i,
  input  logic              xfer_err_i,
  input  logic [NP-1:0][1:0] err_code_i,
  input  logic              clr_done_i,
  input  logic              clr_link_i,
  input  logic              clr_ring_i,
  input  logic              sw_abort_i,
  input  logic              rst_now_i,
  input  logic [NEV:0]      ie_i,
  output logic [DW-1:0]     stat_o,
  output logic              irq_o
);
  localparam int unsigned EV_TOP = S_IRQ - 2;

  logic [NEV-1:0]     ev_q;
  logic [NEV-1:0]     ev_clr;
  logic [NP-1:0][1:0] code_q;
  logic               swab_q, hwab_q, stop_q, end_q, xfer_q;

  always_comb begin
    ev_clr         = '0;
    ev_clr[E_DONE] = clr_done_i;
    ev_clr[E_LINK] = clr_link_i;
    ev_clr[E_RING] = clr_ring_i;
  end

  for (genvar e = 0; e < NEV; e++) begin : g_ev
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ev_q[e] <= 1'b0;
      else if (rst_now_i) ev_q[e] <= 1'b0;
      else if (evt_i[e])  ev_q[e] <= 1'b1;  // new event survives its own clear
      else if (ev_clr[e]) ev_q[e] <= 1'b0;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_code
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        code_q[p] <= '0;
      else if (rst_now_i) code_q[p] <= '0;
      else if (code_q[p] == 2'd0) code_q[p] <= err_code_i[p];  // first code held
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {swab_q, hwab_q, stop_q, end_q, xfer_q} <= '0;
    end else if (rst_now_i) begin
      {swab_q, hwab_q, stop_q, end_q, xfer_q} <= '0;
    end else begin
      swab_q <= swab_q | sw_abort_i;
      hwab_q <= hwab_q | hw_abort_i;
      stop_q <= stop_q | stopped_i;
      end_q  <= end_q  | end_i;
      xfer_q <= xfer_q | xfer_err_i;
    end
  end

  assign irq_o = ie_i[0] & |(ev_q & ie_i[NEV:1]);

  always_comb begin
    stat_o = '0;
    for (int e = 0; e < int'(NEV); e++) stat_o[EV_TOP-2*e] = ev_q[e];
    for (int p = 0; p < int'(NP); p++)  stat_o[2*p +: 2]    = code_q[p];
    stat_o[S_IRQ]  = irq_o;
    stat_o[S_ERR]  = xfer_q | (|code_q);
    stat_o[S_SWAB] = swab_q;
    stat_o[S_HWAB] = hwab_q;
    stat_o[S_STOP] = stop_q;
    stat_o[S_XFER] = xfer_q;
    stat_o[S_END]  = end_q;
  end
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned NEV = N_EV
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_en_i,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  input  logic [NEV-1:0] evt_i,
  input  logic           hw_abort_i,
  input  logic           stopped_i,
  input  logic           end_i,
  input  logic           xfer_err_i,
  input  logic [1:0]     link_err_i,
  input  logic [1:0]     mem_err_i,
  input  logic [1:0]     dev_err_i,
  output logic           start_o,
  output logic           cont_o,
  output logic           stop_o,
  output logic           abort_o,
  output logic           fifo_rst_o,
  output logic           dma_rst_o,
  output logic           fifo_dis_o,
  output logic           burst_en_o,
  output logic           dev_to_mem_o,
  output logic [2:0]     mode_o,
  output logic           irq_o
);
  localparam int unsigned NIE = NEV + 1;

  logic                   cmd_we, ctrl_we;
  logic                   clr_done, clr_link, clr_ring, sw_abort, rst_now;
  logic [NIE-1:0]         ie_vec;
  logic [DW-1:0]          ctrl_word, stat_word;
  logic [N_PORT-1:0][1:0] err_codes;
  act_t                   act;
  chan_cfg_t              cfg;

  assign cmd_we    = reg_en_i & reg_we_i & (reg_addr_i == A_CMD);
  assign ctrl_we   = reg_en_i & reg_we_i & (reg_addr_i == A_CTRL);
  assign err_codes = {link_err_i, mem_err_i, dev_err_i};

  dma_chan_cmd #(.DW(DW)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cmd_we),
    .wdata_i    (reg_wdata_i),
    .act_o      (act),
    .clr_done_o (clr_done),
    .clr_link_o (clr_link),
    .clr_ring_o (clr_ring),
    .sw_abort_o (sw_abort),
    .rst_now_o  (rst_now)
  );

  dma_chan_ctrl #(.DW(DW), .NIE(NIE)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we),
    .wdata_i   (reg_wdata_i),
    .rst_now_i (rst_now),
    .ie_o      (ie_vec),
    .cfg_o     (cfg),
    .rdata_o   (ctrl_word)
  );

  dma_chan_status #(.DW(DW), .NEV(NEV), .NP(N_PORT)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .hw_abort_i (hw_abort_i),
    .stopped_i  (stopped_i),
    .end_i      (end_i),
    .xfer_err_i (xfer_err_i),
    .err_code_i (err_codes),
    .clr_done_i (clr_done),
    .clr_link_i (clr_link),
    .clr_ring_i (clr_ring),
    .sw_abort_i (sw_abort),
    .rst_now_i  (rst_now),
    .ie_i       (ie_vec),
    .stat_o     (stat_word),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_word;
      A_STAT:  reg_rdata_o = stat_word;
      default: reg_rdata_o = '0;
    endcase
  end

  assign start_o      = act.start;
  assign cont_o       = act.cont;
  assign stop_o       = act.stop;
  assign abort_o      = act.abort;
  assign fifo_rst_o   = act.fifo_rst;
  assign dma_rst_o    = act.dma_rst;
  assign fifo_dis_o   = cfg.fifo_dis;
  assign burst_en_o   = cfg.burst_en;
  assign dev_to_mem_o = cfg.dev_to_mem;
  assign mode_o       = cfg.mode;
endmodule

// File: rtl/dma_chan_regs_chk.sv
`timescale 1ns/1ps
module dma_chan_regs_chk #(
  parameter int unsigned DW  = 32,
  parameter int unsigned NIE = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_we,
  input logic           ctrl_we,
  input logic [DW-1:0]  reg_wdata_i,
  input logic           start_o,
  input logic           irq_o,
  input logic [2:0]     mode_o,
  input logic [NIE-1:0] ie_vec,
  input logic [DW-1:0]  stat_word
);
  AST_START_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(cmd_we && reg_wdata_i[0])); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && reg_wdata_i[DW-2]) |=> !ie_vec[0]); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_o == 3'd3 || mode_o == 3'd6 || mode_o == 3'd7)); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_word[25] && !(cmd_we && (reg_wdata_i[7] || reg_wdata_i[0] || reg_wdata_i[31])))
    |=> stat_word[25]); // R7
  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_vec[0]); // R11
  AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && reg_wdata_i[31]) |=> (mode_o == 3'd0 && stat_word == '0)); // R12
  AST_RST_KEEPS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && reg_wdata_i[31] && !ctrl_we) |=> ie_vec == $past(ie_vec)); // R12
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DW(DW), .NIE(NIE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_we      (cmd_we),
  .ctrl_we     (ctrl_we),
  .reg_wdata_i (reg_wdata_i),
  .start_o     (start_o),
  .irq_o       (irq_o),
  .mode_o      (mode_o),
  .ie_vec      (ie_vec),
  .stat_word   (stat_word)
);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  localparam int K_RD = 0, K_ACT = 1, K_IRQ = 2, K_CFG = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_en = 0, reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [6:0]  evt = 0;
  logic        hw_abort = 0, stopped = 0, end_s = 0, xfer_err = 0;
  logic [1:0]  link_err = 0, mem_err = 0, dev_err = 0;
  logic        start, cont, stop, abort, fifo_rst, dma_rst;
  logic        fifo_dis, burst_en, dev_to_mem, irq;
  logic [2:0]  mode;

  int    checks = 0, failures = 0;
  bit    done_flag = 0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk_i(clk), .rst_ni(rst_n), .reg_en_i(reg_en), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .evt_i(evt), .hw_abort_i(hw_abort), .stopped_i(stopped), .end_i(end_s),
    .xfer_err_i(xfer_err), .link_err_i(link_err), .mem_err_i(mem_err),
    .dev_err_i(dev_err), .start_o(start), .cont_o(cont), .stop_o(stop),
    .abort_o(abort), .fifo_rst_o(fifo_rst), .dma_rst_o(dma_rst),
    .fifo_dis_o(fifo_dis), .burst_en_o(burst_en), .dev_to_mem_o(dev_to_mem),
    .mode_o(mode), .irq_o(irq)
  );

  // monitor: pops expectations and compares against the live outputs
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (sb_q.size() > 0);
      #1;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = reg_rdata;
        K_ACT:   act = {26'd0, dma_rst, fifo_rst, abort, stop, cont, start};
        K_IRQ:   act = {31'd0, irq};
        default: act = {26'd0, fifo_dis, burst_en, dev_to_mem, mode};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [1:0] a, input logic [31:0] e,
                      input string tag, input bit now = 0);
    item_t it;
    if (!now) @(negedge clk);
    reg_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    #1 sb_q.push_back(it);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0; reg_wdata = 0;
  endtask

  task automatic ev(input logic [6:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = 0;
  endtask

  task automatic flags(input logic h, input logic s, input logic en, input logic x,
                       input logic [1:0] le, input logic [1:0] me, input logic [1:0] de);
    @(negedge clk);
    hw_abort = h; stopped = s; end_s = en; xfer_err = x;
    link_err = le; mem_err = me; dev_err = de;
    @(negedge clk);
    hw_abort = 0; stopped = 0; end_s = 0; xfer_err = 0;
    link_err = 0; mem_err = 0; dev_err = 0;
  endtask

  initial begin
    #500000;
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    push(K_RD, 2'd1, 32'h0, "R1 ctrl reset");
    push(K_RD, 2'd2, 32'h0, "R1 stat reset");
    push(K_RD, 2'd0, 32'h0, "R1 cmd reads zero");
    push(K_ACT, 2'd0, 32'h0, "R1 no pulses");
    push(K_IRQ, 2'd0, 32'h0, "R1 irq low");
    // R2 action pulses
    wr(2'd0, 32'h1);
    push(K_ACT, 2'd0, 32'h01, "R2 start pulse", 1);
    push(K_ACT, 2'd0, 32'h00, "R2 pulse one cycle");
    wr(2'd0, 32'h8000_001E);
    push(K_ACT, 2'd0, 32'h3E, "R2 multi pulse", 1);
    push(K_RD, 2'd2, 32'h0, "R12 reset beats abort");
    // R3 enable pairs
    wr(2'd1, 32'hAAAA_0000);
    push(K_RD, 2'd1, 32'hAAAA_0000, "R3 set all");
    wr(2'd1, 32'h0000_0000);
    push(K_RD, 2'd1, 32'hAAAA_0000, "R3 zero pair keeps");
    wr(2'd1, 32'h4000_0000);
    push(K_RD, 2'd1, 32'h2AAA_0000, "R3 clear global");
    // R4 clear wins
    wr(2'd1, 32'hC000_0000);
    push(K_RD, 2'd1, 32'h2AAA_0000, "R4 both on cleared stays off");
    wr(2'd1, 32'h8000_0000);
    wr(2'd1, 32'h0300_0000);
    push(K_RD, 2'd1, 32'hA8AA_0000, "R4 both on enabled clears");
    wr(2'd1, 32'h0200_0000);
    push(K_RD, 2'd1, 32'hAAAA_0000, "R3 reset done enable");
    // R5 config fields
    wr(2'd1, 32'h0000_C00C);
    push(K_CFG, 2'd0, 32'h3C, "R5 cfg outputs");
    push(K_RD, 2'd1, 32'hAAAA_C00C, "R5 cfg readback");
    wr(2'd1, 32'h0000_0005);
    push(K_CFG, 2'd0, 32'h05, "R5 long chaining");
    // R6 reserved modes
    wr(2'd1, 32'h0000_4007);
    push(K_CFG, 2'd0, 32'h15, "R6 mode 7 ignored");
    wr(2'd1, 32'h0000_0003);
    push(K_CFG, 2'd0, 32'h05, "R6 mode 3 ignored");
    // R7 sticky done, R11 irq
    ev(7'h04);
    push(K_RD, 2'd2, 32'h8200_0000, "R7 done set");
    push(K_IRQ, 2'd0, 32'h1, "R11 irq on done");
    repeat (4) @(negedge clk);
    push(K_RD, 2'd2, 32'h8200_0000, "R7 done sticky");
    // R13 status writes ignored
    wr(2'd2, 32'hFFFF_FFFF);
    push(K_RD, 2'd2, 32'h8200_0000, "R13 write ones ignored");
    wr(2'd2, 32'h0);
    push(K_RD, 2'd2, 32'h8200_0000, "R13 write zero ignored");
    // R8 clears
    wr(2'd0, 32'h80);
    push(K_RD, 2'd2, 32'h0, "R8 clear done");
    push(K_IRQ, 2'd0, 32'h0, "R8 irq after clear");
    ev(7'h20);
    push(K_RD, 2'd2, 32'h8008_0000, "R7 link complete");
    ev(7'h40);
    push(K_RD, 2'd2, 32'h800A_0000, "R7 ring");
    wr(2'd0, 32'h40);
    push(K_RD, 2'd2, 32'h8008_0000, "R8 clear ring only");
    wr(2'd0, 32'h20);
    push(K_RD, 2'd2, 32'h0, "R8 clear link");
    ev(7'h04);
    wr(2'd0, 32'h1);
    push(K_RD, 2'd2, 32'h0, "R8 start clears done");
    @(negedge clk);
    evt = 7'h04; reg_en = 1; reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'h80;
    @(negedge clk);
    evt = 0; reg_en = 0; reg_we = 0; reg_wdata = 0;
    push(K_RD, 2'd2, 32'h8200_0000, "R8 event beats clear");
    wr(2'd0, 32'h80);
    // R11 gating
    wr(2'd1, 32'h4000_0000);
    ev(7'h01);
    push(K_RD, 2'd2, 32'h2000_0000, "R11 global off");
    push(K_IRQ, 2'd0, 32'h0, "R11 irq off global");
    wr(2'd1, 32'h8000_0000);
    push(K_RD, 2'd2, 32'hA000_0000, "R11 global on");
    push(K_IRQ, 2'd0, 32'h1, "R11 irq on");
    wr(2'd1, 32'h1000_0000);
    push(K_IRQ, 2'd0, 32'h0, "R11 event enable off");
    // R10 flags
    wr(2'd0, 32'h8);
    push(K_ACT, 2'd0, 32'h08, "R2 abort pulse", 1);
    push(K_RD, 2'd2, 32'h2000_4000, "R10 sw abort");
    flags(1, 1, 1, 0, 2'd0, 2'd0, 2'd0);
    push(K_RD, 2'd2, 32'h2000_7100, "R10 hw abort stopped end");
    // R9 errors
    flags(0, 0, 0, 1, 2'd0, 2'd2, 2'd0);
    push(K_RD, 2'd2, 32'h2000_F308, "R9 mem retry error");
    flags(0, 0, 0, 0, 2'd0, 2'd3, 2'd1);
    push(K_RD, 2'd2, 32'h2000_F309, "R9 first code held");
    // R12 full reset
    wr(2'd1, 32'h0000_C00C);
    push(K_RD, 2'd1, 32'h8AAA_C00C, "R5 pre reset ctrl");
    wr(2'd0, 32'h8000_0000);
    push(K_ACT, 2'd0, 32'h20, "R2 reset pulse", 1);
    push(K_RD, 2'd2, 32'h0, "R12 status cleared");
    push(K_RD, 2'd1, 32'h8AAA_0000, "R12 enables kept");
    push(K_CFG, 2'd0, 32'h00, "R12 cfg cleared");
    push(K_RD, 2'd3, 32'h0, "R1 unused address");
    wait (sb_q.size() == 0);
    #5;
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule